// File: doc/BRIEF.md
# APB Transfer Capture Monitor

This block sits passively on an APB bus and turns each finished transfer into one record. A record holds the direction, the address, the data, the byte strobes, the error response and the number of wait states the slave inserted. It never drives the bus. Downstream logic, such as a protocol checker, a scoreboard or a trace recorder, reads the records one at a time over a valid/ready output.

A transfer counts as finished only on a clock edge where select, enable and ready are all high. For a write, the record keeps the write data and strobes. For a read, it keeps the read data present on that edge, whatever the bus showed during earlier wait cycles. Records wait in a small in-order queue. If the queue is full when a transfer finishes, the record is discarded and a sticky overflow flag is raised.

Top module: `apb_xfer_capture`

## Requirements
- R1: A record is created only on a rising clock edge where `psel`, `penable` and `pready` are all 1. A setup cycle (`psel`=1, `penable`=0) with `pready`=1 creates no record. A created record is visible on the outputs right after that edge.
- R2: Access cycles with `penable`=1 and `pready`=0 never create a record.
- R3: For a read (`pwrite`=0), `rec_data` is the `prdata` value sampled on the completion edge, and `rec_strb` is 0.
- R4: For a write (`pwrite`=1), the record holds `rec_write`=1, plus `paddr`, `pwdata` and `pstrb` as sampled on the completion edge.
- R5: `rec_err` is the `pslverr` value sampled on the completion edge. Its value during wait cycles has no effect.
- R6: `rec_waits` equals the number of access cycles with `pready`=0 in that transfer. It is cleared by each setup cycle and saturates at 2^WAIT_W-1, which is 15 by default.
- R7: Back-to-back transfers, where a setup cycle directly follows a completion edge, each produce their own record with their own wait count.
- R8: Records leave in arrival order. Up to DEPTH records are held, 4 by default. `rec_valid` is 1 while at least one record is held, and a record is removed on an edge where `rec_valid` and `rec_ready` are both 1.
- R9: If DEPTH records are already held on a completion edge, the new record is discarded and `overflow` becomes 1. It stays 1 until reset.
- R10: Synchronous active-high `rst` empties the queue, clears the wait counter and clears `overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| psel | input | 1 | Observed slave select |
| penable | input | 1 | Observed access-phase enable |
| pready | input | 1 | Observed slave ready |
| pwrite | input | 1 | Observed direction, 1 = write |
| paddr | input | ADDR_W | Observed address |
| pwdata | input | DATA_W | Observed write data |
| pstrb | input | DATA_W/8 | Observed write byte strobes |
| prdata | input | DATA_W | Observed read data |
| pslverr | input | 1 | Observed error response |
| rec_ready | input | 1 | Consumer accepts the head record |
| rec_valid | output | 1 | A record is available |
| rec_write | output | 1 | Record direction |
| rec_addr | output | ADDR_W | Record address |
| rec_data | output | DATA_W | Write data or read data |
| rec_strb | output | DATA_W/8 | Write strobes, 0 on reads |
| rec_err | output | 1 | Error response at completion |
| rec_waits | output | WAIT_W | Wait-state count |
| overflow | output | 1 | Sticky: a record was discarded |

## Verification
The hardest case to reach from the ports is a wait-stated read where `prdata` and `pslverr` carry misleading values during the stall. A capture that fires one edge early would only be caught in that case. The stimulus therefore drives a distinct decoy value on `prdata` and the inverted error level on every wait cycle, then switches to the true values on the completion cycle. The overflow path is reached by finishing five transfers while `rec_ready` is held low, then draining the queue to confirm that the fifth record is absent.

// File: rtl/apb_cap_pkg.sv
package apb_cap_pkg;

  // Bus phase as seen by the observer on a given cycle.
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_ACCESS = 2'd2
  } ap_phase_t;

  // Classify the current cycle from select and enable.
  function automatic ap_phase_t classify(input logic sel, input logic en);
    if (!sel)     return PH_IDLE;
    else if (!en) return PH_SETUP;
    else          return PH_ACCESS;
  endfunction

endpackage

// File: rtl/apb_cap_tracker.sv
module apb_cap_tracker
  import apb_cap_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WAIT_W = 4,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pready,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [STRB_W-1:0] pstrb,
  input  logic [DATA_W-1:0] prdata,
  input  logic              pslverr,
  output logic              fire,
  output logic              f_write,
  output logic [ADDR_W-1:0] f_addr,
  output logic [DATA_W-1:0] f_data,
  output logic [STRB_W-1:0] f_strb,
  output logic              f_err,
  output logic [WAIT_W-1:0] f_waits
);

  localparam logic [WAIT_W-1:0] WAIT_MAX = {WAIT_W{1'b1}};

  ap_phase_t         phase;
  logic [WAIT_W-1:0] wcnt;

  assign phase = classify(psel, penable);
  assign fire  = (phase == PH_ACCESS) && pready;

  // The stall counter restarts on setup and after completion.
  // During a stall it saturates at its top value.
  always_ff @(posedge clk) begin
    if (rst) begin
      wcnt <= '0;
    end else if (phase == PH_ACCESS && !pready) begin
      if (wcnt != WAIT_MAX) wcnt <= wcnt + 1'b1;
    end else begin
      wcnt <= '0;
    end
  end

  // Record fields, valid only when fire is high.
  always_comb begin
    f_write = pwrite;
    f_addr  = paddr;
    f_err   = pslverr;
    f_waits = wcnt;
    if (pwrite) begin
      f_data = pwdata;
      f_strb = pstrb;
    end else begin
      f_data = prdata;
      f_strb = '0;
    end
  end

  // R6
  wait_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (psel && !penable) |=> (wcnt == '0));

  // R6
  wait_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (psel && penable && !pready && wcnt == WAIT_MAX) |=> (wcnt == WAIT_MAX));

endmodule

// File: rtl/apb_cap_fifo.sv
module apb_cap_fifo #(
  parameter int WIDTH = 58,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_req,
  input  logic [WIDTH-1:0] wr_data,
  output logic             full,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [WIDTH-1:0] rd_data
);

  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] count;
  logic             wr_en, rd_en;

  assign full     = (count == CNT_FULL);
  assign rd_valid = (count != '0);
  assign wr_en    = wr_req && !full;
  assign rd_en    = rd_valid && rd_ready;
  assign rd_data  = mem[rptr];

  // Storage without reset so that a RAM can be inferred.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (wr_en) wptr <= (wptr == PTR_LAST) ? '0 : wptr + 1'b1;
      if (rd_en) rptr <= (rptr == PTR_LAST) ? '0 : rptr + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_req && full && !rd_ready) |=> (count == $past(count)));

  // R8
  pop_count_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && rd_ready && !wr_req) |=> (count == $past(count) - CNT_W'(1)));

endmodule

// File: rtl/apb_xfer_capture.sv
module apb_xfer_capture #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WAIT_W = 4,
  parameter int DEPTH  = 4,
  localparam int STRB_W = DATA_W / 8,
  localparam int REC_W  = 1 + ADDR_W + DATA_W + STRB_W + 1 + WAIT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              psel,
  input  logic              penable,
  input  logic              pready,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic [STRB_W-1:0] pstrb,
  input  logic [DATA_W-1:0] prdata,
  input  logic              pslverr,
  input  logic              rec_ready,
  output logic              rec_valid,
  output logic              rec_write,
  output logic [ADDR_W-1:0] rec_addr,
  output logic [DATA_W-1:0] rec_data,
  output logic [STRB_W-1:0] rec_strb,
  output logic              rec_err,
  output logic [WAIT_W-1:0] rec_waits,
  output logic              overflow
);

  logic              fire, full;
  logic              f_write, f_err;
  logic [ADDR_W-1:0] f_addr;
  logic [DATA_W-1:0] f_data;
  logic [STRB_W-1:0] f_strb;
  logic [WAIT_W-1:0] f_waits;
  logic [REC_W-1:0]  rec_in, rec_out;

  apb_cap_tracker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAIT_W(WAIT_W)
  ) u_track (
    .clk(clk), .rst(rst),
    .psel(psel), .penable(penable), .pready(pready), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata),
    .pslverr(pslverr),
    .fire(fire), .f_write(f_write), .f_addr(f_addr), .f_data(f_data),
    .f_strb(f_strb), .f_err(f_err), .f_waits(f_waits)
  );

  assign rec_in = {f_write, f_addr, f_data, f_strb, f_err, f_waits};

  apb_cap_fifo #(
    .WIDTH(REC_W), .DEPTH(DEPTH)
  ) u_fifo (
    .clk(clk), .rst(rst),
    .wr_req(fire), .wr_data(rec_in), .full(full),
    .rd_valid(rec_valid), .rd_ready(rec_ready), .rd_data(rec_out)
  );

  assign {rec_write, rec_addr, rec_data, rec_strb, rec_err, rec_waits} = rec_out;

  // Sticky flag for a record discarded against a full queue.
  always_ff @(posedge clk) begin
    if (rst)              overflow <= 1'b0;
    else if (fire && full) overflow <= 1'b1;
  end

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!rec_valid && !overflow));

endmodule

// File: tb/apb_xfer_capture_test.sv
module apb_xfer_capture_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        psel = 0, penable = 0, pready = 0, pwrite = 0, pslverr = 0;
  logic [15:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata = '0;
  logic [3:0]  pstrb = '0;
  logic        rec_ready = 0;
  logic        rec_valid, rec_write, rec_err, overflow;
  logic [15:0] rec_addr;
  logic [31:0] rec_data;
  logic [3:0]  rec_strb, rec_waits;

  int tests = 0;
  int fails = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  apb_xfer_capture uut (
    .clk(clk), .rst(rst), .psel(psel), .penable(penable), .pready(pready),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb),
    .prdata(prdata), .pslverr(pslverr), .rec_ready(rec_ready),
    .rec_valid(rec_valid), .rec_write(rec_write), .rec_addr(rec_addr),
    .rec_data(rec_data), .rec_strb(rec_strb), .rec_err(rec_err),
    .rec_waits(rec_waits), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic go_idle();
    psel = 0; penable = 0; pready = 0; pslverr = 0;
  endtask

  // Called at a negedge, returns at the negedge after the completion edge.
  task automatic xfer(input logic w, input logic [15:0] a, input logic [31:0] d,
                      input logic [3:0] s, input int n, input logic e,
                      input logic [31:0] rd);
    psel = 1; penable = 0; pready = 0; pwrite = w; paddr = a;
    pwdata = d; pstrb = s; pslverr = 0; prdata = '0;
    @(negedge clk);
    penable = 1;
    for (int i = 0; i < n; i++) begin
      prdata = 32'hBAD0_0000 + i;
      pslverr = ~e;
      @(negedge clk);
    end
    pready = 1; prdata = rd; pslverr = e;
    @(negedge clk);
    go_idle();
  endtask

  task automatic pop_expect(input string req, input logic w, input logic [15:0] a,
                            input logic [31:0] d, input logic [3:0] s,
                            input logic e, input logic [3:0] n);
    chk(rec_valid === 1'b1, req, 64'(rec_valid), 64'd1);
    chk(rec_write === w && rec_addr === a && rec_data === d &&
        rec_strb === s && rec_err === e && rec_waits === n, req,
        {6'd0, rec_write, rec_err, rec_waits, rec_strb, rec_addr, rec_data},
        {6'd0, w, e, n, s, a, d});
    rec_ready = 1;
    @(negedge clk);
    rec_ready = 0;
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic t_reset();
    // R10: queue empty and flag clear after reset
    chk(rec_valid === 1'b0, "R10 valid after reset", 64'(rec_valid), 64'd0);
    chk(overflow === 1'b0, "R10 overflow after reset", 64'(overflow), 64'd0);
  endtask

  task automatic t_write();
    // R4 and R1: zero-wait write, strobes kept
    xfer(1, 16'h1234, 32'hCAFE_F00D, 4'hA, 0, 0, 32'h0);
    pop_expect("R4 write record", 1, 16'h1234, 32'hCAFE_F00D, 4'hA, 0, 4'd0);
    chk(rec_valid === 1'b0, "R8 empty after pop", 64'(rec_valid), 64'd0);
  endtask

  task automatic t_nofire();
    // R1: setup cycle with ready high must not capture
    psel = 1; penable = 0; pready = 1; pwrite = 0; paddr = 16'h0042;
    @(negedge clk);
    chk(rec_valid === 1'b0, "R1 no capture in setup", 64'(rec_valid), 64'd0);
    penable = 1; pready = 0;
    for (int i = 0; i < 3; i++) begin
      prdata = 32'h5555_0000 + i;
      @(negedge clk);
      // R2: stalled access cycle must not capture
      chk(rec_valid === 1'b0, "R2 no capture while stalled", 64'(rec_valid), 64'd0);
    end
    pready = 1; prdata = 32'h0BAD_BEEF;
    @(negedge clk);
    go_idle();
    chk(rec_valid === 1'b1, "R1 capture at completion", 64'(rec_valid), 64'd1);
    pop_expect("R1 stalled read record", 0, 16'h0042, 32'h0BAD_BEEF, 4'h0, 0, 4'd3);
  endtask

  task automatic t_read_waits();
    // R3: decoy data during waits, true data at completion; strobes ignored
    xfer(0, 16'h0200, 32'hFFFF_FFFF, 4'hF, 4, 0, 32'h1357_9BDF);
    pop_expect("R3 read data at completion", 0, 16'h0200, 32'h1357_9BDF, 4'h0, 0, 4'd4);
  endtask

  task automatic t_err();
    // R5: error high at completion, low while stalled
    xfer(1, 16'h0300, 32'h0000_00AA, 4'h1, 2, 1, 32'h0);
    pop_expect("R5 error captured", 1, 16'h0300, 32'h0000_00AA, 4'h1, 1, 4'd2);
    // R5: error high only while stalled, low at completion
    xfer(0, 16'h0304, 32'h0, 4'h0, 2, 0, 32'h0000_0077);
    pop_expect("R5 stall error ignored", 0, 16'h0304, 32'h0000_0077, 4'h0, 0, 4'd2);
  endtask

  task automatic t_sat();
    // R6: 20 stalled cycles saturate at 15
    xfer(0, 16'h0400, 32'h0, 4'h0, 20, 0, 32'h0000_4444);
    pop_expect("R6 wait count saturates", 0, 16'h0400, 32'h0000_4444, 4'h0, 0, 4'd15);
  endtask

  task automatic t_b2b();
    // R7: three transfers with no idle between them
    xfer(1, 16'h0500, 32'h1111_1111, 4'h3, 0, 0, 32'h0);
    xfer(0, 16'h0504, 32'h0, 4'h0, 2, 0, 32'h2222_2222);
    xfer(1, 16'h0508, 32'h3333_3333, 4'hC, 1, 1, 32'h0);
    pop_expect("R7 first record", 1, 16'h0500, 32'h1111_1111, 4'h3, 0, 4'd0);
    pop_expect("R7 second record", 0, 16'h0504, 32'h2222_2222, 4'h0, 0, 4'd2);
    pop_expect("R7 third record", 1, 16'h0508, 32'h3333_3333, 4'hC, 1, 4'd1);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 4; i++)
      xfer(1, 16'h0600 + 16'(i), 32'hA000_0000 + i, 4'hF, 0, 0, 32'h0);
    chk(overflow === 1'b0, "R9 no overflow at four", 64'(overflow), 64'd0);
    xfer(1, 16'h0604, 32'hA000_0004, 4'hF, 0, 0, 32'h0);
    chk(overflow === 1'b1, "R9 overflow on fifth", 64'(overflow), 64'd1);
    for (int i = 0; i < 4; i++)
      pop_expect("R8 order after fill", 1, 16'h0600 + 16'(i),
                 32'hA000_0000 + i, 4'hF, 0, 4'd0);
    chk(rec_valid === 1'b0, "R9 fifth record dropped", 64'(rec_valid), 64'd0);
    chk(overflow === 1'b1, "R9 overflow sticky", 64'(overflow), 64'd1);
  endtask

  task automatic t_reset_clears();
    xfer(1, 16'h0700, 32'h7, 4'h1, 0, 0, 32'h0);
    do_reset();
    // R10: reset discards the held record and the flag
    chk(rec_valid === 1'b0, "R10 queue emptied", 64'(rec_valid), 64'd0);
    chk(overflow === 1'b0, "R10 overflow cleared", 64'(overflow), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    do_reset();
    t_reset();
    t_write();
    t_nofire();
    t_read_waits();
    t_err();
    t_sat();
    t_b2b();
    t_overflow();
    t_reset_clears();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule